// File: doc/BRIEF.md
# Four-Lane Interleaved Serial-to-Parallel Output Driver

This block is the logic core of a wide display driver. Four shift lanes share one clock, and each lane has its own serial input. All four lanes advance on every rising edge, so four bits are loaded per clock. The lanes are interleaved across the parallel outputs. Output bit k is taken from lane `k mod 4` at stage `k / 4`, so lane 0 feeds bits 0, 4, 8 … 60 and lane 3 feeds bits 3, 7 … 63. A direction input selects one of two shift modes:

- SHIFT_FWD: data enters at stage 0 and moves toward the last stage.
- SHIFT_REV: data enters at the last stage and moves toward stage 0.

No other state or transition exists. The mode is resampled on every edge.

A latch bank sits between the shift lanes and the outputs. While the latch enable is high, the latch bank passes the shift contents straight through. While it is low, the latch bank holds the last value it passed. After the latch bank, a blanking gate and a polarity stage drive the parallel word. Because of this split, the shift lanes can be reloaded without disturbing the displayed pattern. Each lane also has a serial output so that devices can be chained: the serial output of one device connects to the matching serial input of the next.

Top module: `qsp_driver`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all shift stages and held latch values are cleared to zero. After reset, with `latch_en`=1, `blank_n`=1 and `pol`=1, `dout` is all zeros and `sdout` is all zeros.
- R2: With `dir`=1 (forward), each rising edge loads `sdin[l]` into stage 0 of lane l and moves stage s to stage s+1.
- R3: With `dir`=0 (reverse), each rising edge loads `sdin[l]` into stage 15 of lane l and moves stage s to stage s-1.
- R4: Parallel bit k reflects lane k mod 4, stage k div 4. For example, a single one loaded forward into lane 0 reaches bit 60 after 16 clocks.
- R5: `sdout[l]` shows stage 15 of lane l in forward mode and stage 0 of lane l in reverse mode, both before the next edge.
- R6: While `latch_en` is high, the latch view follows the shift contents in the same cycle, and it changes as soon as the shift contents change.
- R7: While `latch_en` is low, `dout` keeps the value latched last, however many shifts occur.
- R8: With `blank_n`=1, `dout` equals the latch view when `pol`=1 and its bitwise inverse when `pol`=0.
- R9: With `blank_n`=0, `dout` is all zeros when `pol`=1 and all ones when `pol`=0.
- R10: `latch_en`, `blank_n` and `pol` have no effect on shifting or on `sdout`.
- R11: Two devices, with the second fed from the first's `sdout`, act as one chain of 32 stages per lane in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | 1 = forward shift, 0 = reverse shift |
| sdin | input | 4 | Serial input, one bit per lane |
| latch_en | input | 1 | 1 = latches transparent, 0 = hold |
| blank_n | input | 1 | Active-low blanking |
| pol | input | 1 | 1 = true outputs, 0 = inverted outputs |
| sdout | output | 4 | Serial cascade output, one bit per lane |
| dout | output | 64 | Parallel output word |

## Verification
The bench targets the interleave boundary with a single one that must land on bit 60. A design that wires the lanes contiguously would instead light bit 15. It flips direction in mid-stream and follows the cascade bits through a second device. A design that takes the serial output from the wrong end would break the 32-stage chain in one of the two directions.

The bench shifts for long runs with the latch enable low. A leaky hold stage would show up as a changing `dout`. It also exercises all four blank and polarity combinations. A design that applies polarity before blanking would blank to the wrong level.

Reset is applied a second time after random traffic. A design with incomplete clearing would show leftover bits at that point.

// File: rtl/qsp_pkg.sv
package qsp_pkg;

    typedef enum logic {
        SHIFT_REV = 1'b0,
        SHIFT_FWD = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/qsp_lane.sv
module qsp_lane
    import qsp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir,
    input  logic             sin,
    output logic [DEPTH-1:0] stages,
    output logic             sout
);

    shift_dir_e mode;
    assign mode = shift_dir_e'(dir);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            unique case (mode)
                SHIFT_FWD: stages <= {stages[DEPTH-2:0], sin};
                SHIFT_REV: stages <= {sin, stages[DEPTH-1:1]};
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            SHIFT_FWD: sout = stages[DEPTH-1];
            SHIFT_REV: sout = stages[0];
        endcase
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> stages == '0); // R1
    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dir) |-> stages[0] == $past(sin)); // R2
    AST_FWD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dir) |-> stages[DEPTH-1] == $past(stages[DEPTH-2])); // R2
    AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dir) |-> stages[DEPTH-1] == $past(sin)); // R3
    AST_SOUT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dir) && dir |-> sout == $past(stages[DEPTH-2])); // R5
    AST_SOUT_REV: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dir) && !dir |-> sout == $past(stages[1])); // R5

endmodule

// File: rtl/qsp_latch_bank.sv
module qsp_latch_bank #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (le) begin
            hold_q <= d;
        end
    end

    assign q = le ? d : hold_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(le) |-> hold_q == $past(hold_q)); // R7
    AST_HOLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(le) |-> hold_q == $past(d)); // R6

endmodule

// File: rtl/qsp_out_stage.sv
module qsp_out_stage #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] latched,
    input  logic             blank_n,
    input  logic             pol,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] gated;

    always_comb begin
        gated = blank_n ? latched : '0;
        dout  = pol ? gated : ~gated;
    end

endmodule

// File: rtl/qsp_driver.sv
module qsp_driver #(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dir,
    input  logic [LANES-1:0]       sdin,
    input  logic                   latch_en,
    input  logic                   blank_n,
    input  logic                   pol,
    output logic [LANES-1:0]       sdout,
    output logic [LANES*DEPTH-1:0] dout
);

    localparam int NOUT = LANES * DEPTH;

    logic [DEPTH-1:0] lane_q [LANES];
    logic [NOUT-1:0]  sr_flat;
    logic [NOUT-1:0]  latch_view;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        qsp_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .dir    (dir),
            .sin    (sdin[l]),
            .stages (lane_q[l]),
            .sout   (sdout[l])
        );
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            assign sr_flat[s*LANES + l] = lane_q[l][s];
        end
    end

    qsp_latch_bank #(.WIDTH(NOUT)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (latch_en),
        .d     (sr_flat),
        .q     (latch_view)
    );

    qsp_out_stage #(.WIDTH(NOUT)) u_out (
        .latched (latch_view),
        .blank_n (blank_n),
        .pol     (pol),
        .dout    (dout)
    );

    AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> dout == {NOUT{~pol}}); // R9
    AST_POL_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        blank_n |-> (dout ^ latch_view) == {NOUT{~pol}}); // R8

endmodule

// File: tb/qsp_driver_tb.sv
module qsp_driver_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir = 1'b1;
    logic [3:0]  sdin = '0;
    logic        latch_en = 1'b0;
    logic        blank_n = 1'b1;
    logic        pol = 1'b1;
    logic [3:0]  sdout_a, sdout_b;
    logic [63:0] dout_a, dout_b;

    int checks = 0;
    int errors = 0;

    logic [63:0] ma_sr = '0, ma_hold = '0, mb_sr = '0, mb_hold = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qsp_driver dut_i (
        .clk(clk), .rst_n(rst_n), .dir(dir), .sdin(sdin), .latch_en(latch_en),
        .blank_n(blank_n), .pol(pol), .sdout(sdout_a), .dout(dout_a)
    );

    qsp_driver dut_b (
        .clk(clk), .rst_n(rst_n), .dir(dir), .sdin(sdout_a), .latch_en(latch_en),
        .blank_n(blank_n), .pol(pol), .sdout(sdout_b), .dout(dout_b)
    );

    function automatic logic [63:0] model_shift(logic [63:0] v, logic d, logic [3:0] si);
        for (int l = 0; l < 4; l++) begin
            if (d) begin
                for (int s = 15; s > 0; s--) v[4*s+l] = v[4*(s-1)+l];
                v[l] = si[l];
            end else begin
                for (int s = 0; s < 15; s++) v[4*s+l] = v[4*(s+1)+l];
                v[60+l] = si[l];
            end
        end
        return v;
    endfunction

    function automatic logic [3:0] model_sout(logic [63:0] v, logic d);
        logic [3:0] r;
        for (int l = 0; l < 4; l++) r[l] = d ? v[60+l] : v[l];
        return r;
    endfunction

    function automatic logic [63:0] model_dout(logic [63:0] sr, logic [63:0] hold,
                                               logic le, logic bn, logic p);
        logic [63:0] v;
        v = le ? sr : hold;
        if (!bn) v = '0;
        return p ? v : ~v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic [3:0] si, input logic le,
                        input logic bn, input logic p, input string tag);
        logic [3:0] a_out;
        dir = d; sdin = si; latch_en = le; blank_n = bn; pol = p;
        #1;
        check(tag, dout_a, model_dout(ma_sr, ma_hold, le, bn, p));
        check("R5", {60'd0, sdout_a}, {60'd0, model_sout(ma_sr, d)});
        check("R11", dout_b, model_dout(mb_sr, mb_hold, le, bn, p));
        check("R11", {60'd0, sdout_b}, {60'd0, model_sout(mb_sr, d)});
        a_out = model_sout(ma_sr, d);
        @(posedge clk);
        if (le) begin
            ma_hold = ma_sr;
            mb_hold = mb_sr;
        end
        ma_sr = model_shift(ma_sr, d, si);
        mb_sr = model_shift(mb_sr, d, a_out);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ma_sr = '0; ma_hold = '0; mb_sr = '0; mb_hold = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: cleared state seen through transparent latches
        step(1'b1, 4'h0, 1'b1, 1'b1, 1'b1, "R1");
        do_reset();

        // R4: single one on lane 0 must reach bit 60 after 16 forward clocks
        step(1'b1, 4'b0001, 1'b0, 1'b1, 1'b1, "R4");
        for (int i = 0; i < 15; i++) step(1'b1, 4'h0, 1'b0, 1'b1, 1'b1, "R4");
        latch_en = 1'b1; #1;
        check("R4", dout_a, 64'h1 << 60);
        check("R5", {60'd0, sdout_a}, 64'h1);

        // R2: forward loading with transparent latches
        for (int i = 0; i < 24; i++) step(1'b1, 4'($urandom), 1'b1, 1'b1, 1'b1, "R2");
        // R3: reverse loading
        for (int i = 0; i < 24; i++) step(1'b0, 4'($urandom), 1'b1, 1'b1, 1'b1, "R3");
        // R6: transparency with direction flips
        for (int i = 0; i < 16; i++) step(1'($urandom), 4'($urandom), 1'b1, 1'b1, 1'b1, "R6");
        // R7: hold while shifting continues
        for (int i = 0; i < 30; i++) step(1'($urandom), 4'($urandom), 1'b0, 1'b1, 1'b1, "R7");
        // R8: inverted polarity
        for (int i = 0; i < 10; i++) step(1'b1, 4'($urandom), 1'b1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 4; i++)  step(1'b0, 4'($urandom), 1'b0, 1'b1, 1'b0, "R8");
        // R9: blanking at both polarities
        for (int i = 0; i < 6; i++) step(1'b1, 4'($urandom), 1'b1, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, 4'($urandom), 1'b1, 1'b0, 1'b0, "R9");
        // R10: random controls must not disturb shifting
        for (int i = 0; i < 200; i++)
            step(1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R10");
        // R11: long cascaded runs in each direction
        for (int i = 0; i < 40; i++) step(1'b1, 4'($urandom), 1'b1, 1'b1, 1'b1, "R11");
        for (int i = 0; i < 40; i++) step(1'b0, 4'($urandom), 1'b1, 1'b1, 1'b1, "R11");

        // R1: reset after traffic clears everything
        do_reset();
        step(1'b1, 4'h0, 1'b1, 1'b1, 1'b1, "R1");
        step(1'b0, 4'h0, 1'b0, 1'b1, 1'b1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule